// File: doc/BRIEF.md
# Packed floating-point lane comparator

This unit compares two packed operand vectors lane by lane and produces a mask that is one element wide per lane. A lane of the mask is all ones when its test passes and all zeros when it fails. The lanes can hold half, single or double precision values. The active part of the vector is 64 bits, 128 bits or a single scalar element. The available tests are equal, greater-or-equal and greater-than, and each greater test can also run on absolute values. A 3-bit operation code selects the test. Codes that are not defined, and the one format that is not allowed, raise an illegal indication.

The comparison follows IEEE-754 ordering. A comparison with a NaN fails. Signed zeros compare as equal. Subnormal values are compared at their exact values. An invalid-operation flag collects the NaN cases from the active lanes only. The block registers its result. A request accepted on one clock edge shows its result on `valid_o` after the next edge. The block accepts a new request on every cycle.

Top module: `fp_lane_cmp`

## Requirements
- R1: `op_i` selects the test. 3'b000 is equal, 3'b010 is greater-or-equal, 3'b011 is greater-or-equal on absolute values, 3'b110 is greater-than and 3'b111 is greater-than on absolute values. Codes 3'b001, 3'b100 and 3'b101 set `illegal_o`. An illegal request returns an all-zero mask and `invalid_o` low, even when NaN operands are present.
- R2: The lane width depends on the format inputs. When `half_i`=1 the lanes are 16 bits wide. Otherwise the lanes are 32 bits wide when `size_i`=0 and 64 bits wide when `size_i`=1. Lane k occupies bits [k*W +: W], where W is the lane width.
- R3: When `wide_i`=1 the whole 128 bits are active. When `wide_i`=0 only bits [63:0] are active, and `mask_o[127:64]` is zero.
- R4: In vector mode, `half_i`=0 with `size_i`=1 and `wide_i`=0 (64-bit lanes in a 64-bit vector) sets `illegal_o`.
- R5: When `scalar_i`=1 only lane 0 is compared and every mask bit above lane 0 is zero. In scalar mode, 64-bit lanes are legal for either value of `wide_i`.
- R6: Every result lane is either all ones or all zeros.
- R7: In the absolute modes the sign bit of both elements is cleared before the comparison.
- R8: Any comparison with a NaN operand fails. For greater-or-equal and greater-than, any NaN sets `invalid_o`. For equal, only a signalling NaN sets `invalid_o`, where a signalling NaN has the top mantissa bit clear.
- R9: +0 and -0 compare as equal. When both operands are negative, the larger magnitude is the smaller value.
- R10: Subnormal operands are compared at their exact values. They are not flushed to zero.
- R11: `invalid_o` is the OR of the per-lane flags from the active lanes only. A NaN in an inactive lane has no effect.
- R12: `valid_o`, `mask_o`, `invalid_o` and `illegal_o` update on the clock edge after the one that accepts `valid_i`. After reset all of these outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| half_i | input | 1 | Selects 16-bit lanes |
| size_i | input | 1 | Selects 64-bit lanes over 32-bit lanes when `half_i`=0 |
| wide_i | input | 1 | Selects a 128-bit active width over a 64-bit active width |
| scalar_i | input | 1 | Compares lane 0 only |
| a_i | input | 128 | First operand vector |
| b_i | input | 128 | Second operand vector |
| valid_o | output | 1 | Result strobe |
| mask_o | output | 128 | Per-lane result mask |
| invalid_o | output | 1 | Invalid-operation flag |
| illegal_o | output | 1 | Illegal operation code or format |

## Verification
Two functions can meet on the same request: the illegal-code decode and the NaN detection in the lanes. Each one would otherwise drive `invalid_o` on its own. The bench sends reserved codes with signalling NaNs in every lane and expects `illegal_o` high, `invalid_o` low and a zero mask. The same kind of overlap arises between the active-lane limit and NaN detection. Signalling NaNs are placed in lanes that are inactive because of a narrow or scalar request, and the same data is then sent as a full-width request, so the flag must change only with the width.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;
  typedef enum logic [1:0] {CMP_EQ, CMP_GE, CMP_GT} cmp_e;
  typedef enum logic [1:0] {ESZ_16, ESZ_32, ESZ_64} esz_e;
endpackage

// File: rtl/fp_cmp_decode.sv
module fp_cmp_decode
  import fp_cmp_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [2:0]       op_i,
  input  logic             half_i,
  input  logic             size_i,
  input  logic             wide_i,
  input  logic             scalar_i,
  output cmp_e             cmp_o,
  output logic             abs_o,
  output esz_e             esz_o,
  output logic [VEC_W-1:0] act_o,
  output logic             illegal_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic        op_ok;
  int unsigned ew;
  int unsigned width;

  always_comb begin
    op_ok = 1'b1;
    cmp_o = CMP_EQ;
    abs_o = 1'b0;
    unique case (op_i)
      3'b000: cmp_o = CMP_EQ;
      3'b010: cmp_o = CMP_GE;
      3'b011: begin cmp_o = CMP_GE; abs_o = 1'b1; end
      3'b110: cmp_o = CMP_GT;
      3'b111: begin cmp_o = CMP_GT; abs_o = 1'b1; end
      default: op_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (half_i) begin
      esz_o = ESZ_16; ew = 16;
    end else if (size_i) begin
      esz_o = ESZ_64; ew = 64;
    end else begin
      esz_o = ESZ_32; ew = 32;
    end
    width = scalar_i ? ew : (wide_i ? VEC_W : HALF_W);
    for (int unsigned i = 0; i < VEC_W; i++) act_o[i] = (i < width);
  end

  // 64-bit lanes in a 64-bit vector is a reserved format
  assign illegal_o = !op_ok || (!half_i && size_i && !wide_i && !scalar_i);
endmodule

// File: rtl/fp_cmp_lane.sv
module fp_cmp_lane
  import fp_cmp_pkg::*;
#(
  parameter int unsigned EW = 16,
  parameter int unsigned MW = 10
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  cmp_e          cmp_i,
  input  logic          abs_i,
  output logic          pass_o,
  output logic          inv_o
);
  logic [EW-1:0] a, b;
  logic          nan_a, nan_b, snan_a, snan_b, any_nan;
  logic          zeros, eq, gt;

  assign a = abs_i ? {1'b0, a_i[EW-2:0]} : a_i;
  assign b = abs_i ? {1'b0, b_i[EW-2:0]} : b_i;

  assign nan_a  = (&a[EW-2:MW]) && (|a[MW-1:0]);
  assign nan_b  = (&b[EW-2:MW]) && (|b[MW-1:0]);
  assign snan_a = nan_a && !a[MW-1];
  assign snan_b = nan_b && !b[MW-1];
  assign any_nan = nan_a || nan_b;

  assign zeros = (a[EW-2:0] == '0) && (b[EW-2:0] == '0);
  assign eq    = zeros || (a == b);

  always_comb begin
    unique case ({a[EW-1], b[EW-1]})
      2'b00:   gt = a[EW-2:0] > b[EW-2:0];
      2'b11:   gt = a[EW-2:0] < b[EW-2:0];
      2'b01:   gt = !zeros;
      default: gt = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cmp_i)
      CMP_EQ:  pass_o = !any_nan && eq;
      CMP_GE:  pass_o = !any_nan && (eq || gt);
      default: pass_o = !any_nan && gt;
    endcase
    inv_o = (cmp_i == CMP_EQ) ? (snan_a || snan_b) : any_nan;
  end
endmodule

// File: rtl/fp_cmp_bank.sv
module fp_cmp_bank
  import fp_cmp_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 16,
  parameter int unsigned MW    = 10
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  cmp_e             cmp_i,
  input  logic             abs_i,
  input  logic [VEC_W-1:0] act_i,
  output logic [VEC_W-1:0] mask_o,
  output logic             inv_o
);
  localparam int unsigned NL = VEC_W / EW;

  logic [NL-1:0] lane_inv;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic pass, inv;
    fp_cmp_lane #(.EW(EW), .MW(MW)) u_lane (
      .a_i   (a_i[g*EW +: EW]),
      .b_i   (b_i[g*EW +: EW]),
      .cmp_i (cmp_i),
      .abs_i (abs_i),
      .pass_o(pass),
      .inv_o (inv)
    );
    assign mask_o[g*EW +: EW] = {EW{pass}} & act_i[g*EW +: EW];
    assign lane_inv[g]        = inv & act_i[g*EW];
  end

  assign inv_o = |lane_inv;
endmodule

// File: rtl/fp_lane_cmp.sv
module fp_lane_cmp
  import fp_cmp_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic             half_i,
  input  logic             size_i,
  input  logic             wide_i,
  input  logic             scalar_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] mask_o,
  output logic             invalid_o,
  output logic             illegal_o
);
  cmp_e             cmp;
  logic             abs_en, illegal;
  esz_e             esz;
  logic [VEC_W-1:0] act;
  logic [VEC_W-1:0] m16, m32, m64, mask_sel;
  logic             i16, i32, i64, inv_sel;

  fp_cmp_decode #(.VEC_W(VEC_W)) u_dec (
    .op_i     (op_i),
    .half_i   (half_i),
    .size_i   (size_i),
    .wide_i   (wide_i),
    .scalar_i (scalar_i),
    .cmp_o    (cmp),
    .abs_o    (abs_en),
    .esz_o    (esz),
    .act_o    (act),
    .illegal_o(illegal)
  );

  fp_cmp_bank #(.VEC_W(VEC_W), .EW(16), .MW(10)) u_b16 (
    .a_i(a_i), .b_i(b_i), .cmp_i(cmp), .abs_i(abs_en), .act_i(act),
    .mask_o(m16), .inv_o(i16)
  );
  fp_cmp_bank #(.VEC_W(VEC_W), .EW(32), .MW(23)) u_b32 (
    .a_i(a_i), .b_i(b_i), .cmp_i(cmp), .abs_i(abs_en), .act_i(act),
    .mask_o(m32), .inv_o(i32)
  );
  fp_cmp_bank #(.VEC_W(VEC_W), .EW(64), .MW(52)) u_b64 (
    .a_i(a_i), .b_i(b_i), .cmp_i(cmp), .abs_i(abs_en), .act_i(act),
    .mask_o(m64), .inv_o(i64)
  );

  always_comb begin
    unique case (esz)
      ESZ_16:  begin mask_sel = m16; inv_sel = i16; end
      ESZ_32:  begin mask_sel = m32; inv_sel = i32; end
      default: begin mask_sel = m64; inv_sel = i64; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      mask_o    <= '0;
      invalid_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mask_o    <= illegal ? '0 : mask_sel;
        invalid_o <= !illegal && inv_sel;
        illegal_o <= illegal;
      end
    end
  end
endmodule

// File: rtl/fp_lane_cmp_chk.sv
module fp_lane_cmp_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic             half_i,
  input logic             size_i,
  input logic             wide_i,
  input logic             scalar_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] mask_o,
  input logic             invalid_o,
  input logic             illegal_o
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R12
  AST_RESERVED_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'b001 || op_i == 3'b100 || op_i == 3'b101) |=> illegal_o); // R1
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> (mask_o == '0) && !invalid_o); // R1
  AST_DBL_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !half_i && size_i && !wide_i && !scalar_i |=> illegal_o); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> mask_o[VEC_W-1:VEC_W/2] == '0); // R3
  AST_SCALAR_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scalar_i && half_i |=> mask_o[VEC_W-1:16] == '0); // R5

  for (genvar g = 0; g < VEC_W / 16; g++) begin : g_full
    AST_LANE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (mask_o[g*16 +: 16] == '0) || (mask_o[g*16 +: 16] == '1)); // R6
  end
endmodule

bind fp_lane_cmp fp_lane_cmp_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/fp_lane_cmp_test.sv
module fp_lane_cmp_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic         half_i = 1'b0, size_i = 1'b0, wide_i = 1'b0, scalar_i = 1'b0;
  logic [127:0] a_i = '0, b_i = '0;
  logic         valid_o, invalid_o, illegal_o;
  logic [127:0] mask_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [127:0] mask;
    bit           inv;
    bit           ill;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  fp_lane_cmp uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .half_i(half_i), .size_i(size_i), .wide_i(wide_i), .scalar_i(scalar_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .mask_o(mask_o),
    .invalid_o(invalid_o), .illegal_o(illegal_o)
  );

  // reference: order through a sortable unsigned key
  function automatic void ref_lane(input logic [63:0] xi, input logic [63:0] yi,
                                   input int ew, input int cmp, input bit absm,
                                   output bit pass, output bit inv);
    int eb;
    int mb;
    logic [63:0] lm, sbit, emask, mmask, qbit, x, y, kx, ky;
    bit nx, ny, sx, sy;
    eb = (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
    mb = ew - eb - 1;
    lm = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
    sbit = 64'd1 << (ew - 1);
    emask = ((64'd1 << eb) - 1) << mb;
    mmask = (64'd1 << mb) - 1;
    qbit = 64'd1 << (mb - 1);
    x = xi & lm;
    y = yi & lm;
    if (absm) begin x = x & ~sbit; y = y & ~sbit; end
    nx = ((x & emask) == emask) && ((x & mmask) != 0);
    ny = ((y & emask) == emask) && ((y & mmask) != 0);
    sx = nx && ((x & qbit) == 0);
    sy = ny && ((y & qbit) == 0);
    if ((x & ~sbit) == 0) kx = sbit; else if ((x & sbit) != 0) kx = ~x & lm; else kx = x | sbit;
    if ((y & ~sbit) == 0) ky = sbit; else if ((y & sbit) != 0) ky = ~y & lm; else ky = y | sbit;
    if (nx || ny) pass = 0;
    else if (cmp == 0) pass = (kx == ky);
    else if (cmp == 1) pass = (kx >= ky);
    else pass = (kx > ky);
    inv = (cmp == 0) ? (sx || sy) : (nx || ny);
  endfunction

  task automatic drive(input logic [2:0] op, input bit half, input bit sz, input bit wide,
                       input bit scal, input logic [127:0] a, input logic [127:0] b,
                       input string tag);
    exp_t e;
    int ew, width, cmp;
    bit absm, p, iv;
    logic [63:0] lm;
    e.tag = tag;
    e.mask = '0;
    e.inv = 0;
    e.ill = !(op == 3'b000 || op == 3'b010 || op == 3'b011 || op == 3'b110 || op == 3'b111)
            || (!half && sz && !wide && !scal);
    ew = half ? 16 : (sz ? 64 : 32);
    width = scal ? ew : (wide ? 128 : 64);
    cmp = op[2] ? 2 : (op[1] ? 1 : 0);
    absm = op[1] & op[0];
    lm = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
    if (!e.ill) begin
      for (int l = 0; l * ew < width; l++) begin
        ref_lane(64'(a >> (l * ew)) & lm, 64'(b >> (l * ew)) & lm, ew, cmp, absm, p, iv);
        if (p) e.mask = e.mask | (128'(lm) << (l * ew));
        if (iv) e.inv = 1;
      end
    end
    @(negedge clk);
    valid_i = 1'b1; op_i = op; half_i = half; size_i = sz; wide_i = wide;
    scalar_i = scal; a_i = a; b_i = b;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected valid_o: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (mask_o !== e.mask || invalid_o !== e.inv || illegal_o !== e.ill) begin
          errors++;
          $display("FAIL %s: mask %h inv %0d ill %0d, expected mask %h inv %0d ill %0d",
                   e.tag, mask_o, invalid_o, illegal_o, e.mask, e.inv, e.ill);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [127:0] HA = {16'h0002, 16'h0001, 16'h8000, 16'h0000,
                                 16'hC000, 16'hBC00, 16'h4000, 16'h3C00};
  localparam logic [127:0] HB = {16'h0001, 16'h0002, 16'h0000, 16'h8000,
                                 16'hBC00, 16'hC000, 16'h3C00, 16'h4000};
  localparam logic [127:0] SA = {32'hBF800000, 32'h00000001, 32'h40000000, 32'h3F800000};
  localparam logic [127:0] SB = {32'hC0000000, 32'h00000002, 32'h3F800000, 32'h3F800000};
  localparam logic [127:0] DA = {64'hC000000000000000, 64'h3FF0000000000000};
  localparam logic [127:0] DB = {64'hBFF0000000000000, 64'h3FF0000000000000};
  localparam logic [127:0] ONES_H = {8{16'h3C00}};

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || mask_o !== '0 || invalid_o !== 1'b0 || illegal_o !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: valid %0d mask %h inv %0d ill %0d, expected all zero",
               valid_o, mask_o, invalid_o, illegal_o);
    end
    rst_n = 1'b1;

    drive(3'b000, 1, 0, 1, 0, HA, HB, "R1 R9 half eq");
    drive(3'b010, 1, 0, 1, 0, HA, HB, "R9 R10 half ge");
    drive(3'b011, 1, 0, 1, 0, HA, HB, "R7 half abs ge");
    drive(3'b110, 1, 0, 1, 0, HA, HB, "R2 R9 half gt");
    drive(3'b111, 1, 0, 1, 0, HA, HB, "R7 half abs gt");
    drive(3'b001, 1, 0, 1, 0, HA, HB, "R1 reserved 001");
    drive(3'b100, 1, 0, 1, 0, HA, HB, "R1 reserved 100");
    drive(3'b101, 0, 0, 1, 0, SA, SB, "R1 reserved 101");
    drive(3'b010, 0, 0, 1, 0, SA, SB, "R2 R6 single ge");
    drive(3'b111, 0, 0, 1, 0, SA, SB, "R7 R10 single abs gt");
    drive(3'b010, 0, 0, 0, 0, SA, SB, "R3 single narrow");
    drive(3'b010, 0, 1, 1, 0, DA, DB, "R2 R9 double ge");
    drive(3'b011, 0, 1, 1, 0, DA, DB, "R7 double abs ge");
    drive(3'b010, 0, 1, 0, 0, DA, DB, "R4 double narrow reserved");
    drive(3'b000, 0, 1, 0, 1, DA, DB, "R5 scalar double");
    drive(3'b010, 1, 0, 1, 1, {{7{16'h7C01}}, 16'h3C00}, {{7{16'h7C01}}, 16'h3C00},
          "R5 R11 scalar half inactive snan");
    drive(3'b000, 1, 0, 1, 0, {ONES_H[127:48], 16'h7C00, 16'h7C01, 16'h7E00},
          {ONES_H[127:48], 16'h7C00, 16'h3C00, 16'h3C00}, "R8 eq with snan");
    drive(3'b000, 1, 0, 1, 0, {ONES_H[127:16], 16'h7E00}, ONES_H, "R8 eq quiet nan");
    drive(3'b110, 1, 0, 1, 0, {ONES_H[127:16], 16'h7E00}, ONES_H, "R8 gt quiet nan");
    drive(3'b010, 1, 0, 0, 0, {ONES_H[127:96], 16'h7C01, ONES_H[79:0]}, ONES_H,
          "R11 narrow inactive snan");
    drive(3'b010, 1, 0, 1, 0, {ONES_H[127:96], 16'h7C01, ONES_H[79:0]}, ONES_H,
          "R11 wide active snan");
    drive(3'b001, 1, 0, 1, 0, {8{16'h7C01}}, {8{16'h7C01}}, "R1 illegal over nan");
    drive(3'b010, 0, 0, 1, 1, {SA[127:32], 32'h7F800001}, SB, "R5 R8 scalar single snan");

    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || sb.size() != 0) begin
      errors++;
      $display("FAIL R12 drain: valid %0d pending %0d, expected 0 and 0", valid_o, sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule